// File: doc/BRIEF.md
# Temperature-Trimmed Second Prescaler

This block turns a 32768 Hz crystal clock into a one-second strobe that can be sped up in steps of roughly one part per million. Crystal error that drifts with temperature is cancelled by making some seconds one input cycle longer than nominal: a second normally lasts 32768 input cycles, and a corrected second lasts 32769. Using the longer divisor on every second shifts the rate by about 30 ppm. One ppm at 32768 Hz is about 0.0328 Hz, or about 31.5 seconds per year.

The correction is applied over a repeating frame of 30 seconds. A correction count n, supplied by an external temperature path, selects how many seconds in each frame use the longer divisor. The other seconds use the nominal one, so each step of n is worth about 1 ppm. The long seconds are spread through the frame by a phase accumulator rather than grouped together, which keeps the short-term error small.

A new n is picked up only at a frame boundary. Two strobes come out: one marks the last input cycle of every second, and the other marks the last input cycle of every frame. No processor work is needed once n is driven.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) keeps both strobes low. The active correction is cleared to 0, so every second of the first frame after reset is short, whatever `corr_n` holds. The first `sec_tick` comes DIV_NOM cycles after the first edge with `rst` low.
- R2: With an active correction of 0, `sec_tick` repeats every DIV_NOM input cycles.
- R3: `sec_tick` is high for exactly one input cycle, the last cycle of its second.
- R4: `frame_tick` is high only together with `sec_tick`, on every FRAME_LEN-th second. The count starts from reset.
- R5: In a frame whose active correction is n, exactly n seconds last DIV_NOM+1 cycles and FRAME_LEN−n seconds last DIV_NOM cycles.
- R6: Second k of a frame (k = 0 … FRAME_LEN−1) is long exactly when floor((k+1)·n/FRAME_LEN) exceeds floor(k·n/FRAME_LEN).
- R7: `corr_n` is sampled only on the clock edge that ends a frame (the edge where `frame_tick` is high). A change in the middle of a frame leaves that frame unchanged and applies to the next one.
- R8: A `corr_n` value above FRAME_LEN is saturated to FRAME_LEN.
- R9: With an active correction of FRAME_LEN, every second in the frame lasts DIV_NOM+1 cycles.
- R10: A frame with active correction n lasts FRAME_LEN·DIV_NOM + n input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate input clock |
| rst | input | 1 | Synchronous reset, active high |
| corr_n | input | CORR_W | Requested count of long seconds per frame (unsigned) |
| sec_tick | output | 1 | One-cycle strobe at the last cycle of each second |
| frame_tick | output | 1 | One-cycle strobe at the last cycle of each frame |

## Verification
The bench runs with a shortened divisor and frame length. It steps the correction through several values:
- zero, which separates nominal timing from any long-second leakage;
- the full frame length, which shows that every second is stretched;
- a value above the frame length, which exercises saturation;
- intermediate values (1, 2, 3, 4, 5), where the position of each long second inside the frame tells even spreading apart from grouping.

Each new value is driven partway through a frame, so that a design which takes the value immediately shows a wrong period in the frame where the change happened. A second reset, applied partway through a second while a nonzero request is held, checks that the first frame after reset is uncorrected and that the request takes hold one frame later.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   // Bits needed to hold values 0 .. max_val
   function automatic int unsigned span_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

   // Per-second decision handed from the frame sequencer to the cycle counter
   typedef enum logic {
      SEC_SHORT = 1'b0,
      SEC_LONG  = 1'b1
   } sec_len_e;

endpackage

// File: rtl/rtc_trim_corr_sat.sv
module rtc_trim_corr_sat #(
   parameter int unsigned FRAME_LEN = 30,
   parameter int unsigned CORR_W    = 5
) (
   input  logic [CORR_W-1:0] corr_in,
   output logic [CORR_W-1:0] corr_out
);

   localparam logic [CORR_W-1:0] CORR_MAX = CORR_W'(FRAME_LEN);

   generate
      if ((2 ** CORR_W) - 1 > FRAME_LEN) begin : g_clamp
         always_comb begin
            corr_out = (corr_in > CORR_MAX) ? CORR_MAX : corr_in;
         end
      end else begin : g_pass
         assign corr_out = corr_in;
      end
   endgenerate

endmodule

// File: rtl/rtc_trim_cycle_ctr.sv
module rtc_trim_cycle_ctr
   import rtc_trim_pkg::*;
#(
   parameter int unsigned DIV_NOM = 32768,
   parameter int unsigned CNT_W   = 16
) (
   input  logic     clk,
   input  logic     rst,
   input  sec_len_e sec_len,
   output logic     sec_tick
);

   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DIV_NOM - 1);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DIV_NOM);

   logic [CNT_W-1:0] cyc_q;
   logic [CNT_W-1:0] cyc_last;

   always_comb begin
      cyc_last = (sec_len == SEC_LONG) ? LAST_LONG : LAST_SHORT;
      sec_tick = (cyc_q == cyc_last);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_q <= '0;
      end else if (sec_tick) begin
         cyc_q <= '0;
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_trim_frame_seq.sv
module rtc_trim_frame_seq
   import rtc_trim_pkg::*;
#(
   parameter int unsigned FRAME_LEN = 30,
   parameter int unsigned CORR_W    = 5,
   parameter int unsigned POS_W     = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sec_tick,
   input  logic [CORR_W-1:0] corr_sat,
   output sec_len_e          sec_len,
   output logic              frame_tick,
   output logic [CORR_W-1:0] act_corr
);

   localparam int unsigned   SUM_W    = CORR_W + 1;
   localparam logic [SUM_W-1:0] FRAME_S = SUM_W'(FRAME_LEN);
   localparam logic [POS_W-1:0] POS_END = POS_W'(FRAME_LEN - 1);

   logic [POS_W-1:0]  pos_q;
   logic [CORR_W-1:0] phase_q;
   logic [CORR_W-1:0] act_q;
   logic [SUM_W-1:0]  phase_sum;
   logic [SUM_W-1:0]  phase_next;
   logic              wrap;

   // Phase accumulator: a long second is issued whenever phase crosses FRAME_LEN
   always_comb begin
      phase_sum  = {1'b0, phase_q} + {1'b0, act_q};
      wrap       = (phase_sum >= FRAME_S);
      phase_next = wrap ? (phase_sum - FRAME_S) : phase_sum;
      sec_len    = wrap ? SEC_LONG : SEC_SHORT;
      frame_tick = sec_tick && (pos_q == POS_END);
      act_corr   = act_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q   <= '0;
         phase_q <= '0;
         act_q   <= '0;
      end else if (frame_tick) begin
         pos_q   <= '0;
         phase_q <= '0;
         act_q   <= corr_sat;
      end else if (sec_tick) begin
         pos_q   <= pos_q + 1'b1;
         phase_q <= phase_next[CORR_W-1:0];
      end
   end

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
   import rtc_trim_pkg::*;
#(
   parameter int unsigned DIV_NOM   = 32768,
   parameter int unsigned FRAME_LEN = 30,
   parameter int unsigned CORR_W    = span_bits(FRAME_LEN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CORR_W-1:0] corr_n,
   output logic              sec_tick,
   output logic              frame_tick
);

   localparam int unsigned CNT_W = span_bits(DIV_NOM);
   localparam int unsigned POS_W = span_bits(FRAME_LEN - 1);

   generate
      if (DIV_NOM < 2) begin : g_bad_div
         $error("DIV_NOM must be at least 2");
      end
      if (FRAME_LEN < 2) begin : g_bad_frame
         $error("FRAME_LEN must be at least 2");
      end
      if (CORR_W < span_bits(FRAME_LEN)) begin : g_bad_corr
         $error("CORR_W too narrow for FRAME_LEN");
      end
   endgenerate

   logic [CORR_W-1:0] corr_sat;
   logic [CORR_W-1:0] act_corr;
   sec_len_e          sec_len;

   rtc_trim_corr_sat #(
      .FRAME_LEN (FRAME_LEN),
      .CORR_W    (CORR_W)
   ) u_sat (
      .corr_in  (corr_n),
      .corr_out (corr_sat)
   );

   rtc_trim_frame_seq #(
      .FRAME_LEN (FRAME_LEN),
      .CORR_W    (CORR_W),
      .POS_W     (POS_W)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .sec_tick   (sec_tick),
      .corr_sat   (corr_sat),
      .sec_len    (sec_len),
      .frame_tick (frame_tick),
      .act_corr   (act_corr)
   );

   rtc_trim_cycle_ctr #(
      .DIV_NOM (DIV_NOM),
      .CNT_W   (CNT_W)
   ) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .sec_len  (sec_len),
      .sec_tick (sec_tick)
   );

endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
module rtc_trim_prescaler_chk
   import rtc_trim_pkg::*;
#(
   parameter int unsigned DIV_NOM   = 32768,
   parameter int unsigned FRAME_LEN = 30,
   parameter int unsigned CORR_W    = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              sec_tick,
   input logic              frame_tick,
   input logic [CORR_W-1:0] act_corr
);

   localparam int unsigned CNT_W = span_bits(DIV_NOM);
   localparam int unsigned POS_W = span_bits(FRAME_LEN - 1);

   logic [CNT_W-1:0]  gap_q;
   logic [POS_W-1:0]  secs_q;
   logic [CORR_W:0]   longs_q;
   logic              cur_long;

   assign cur_long = sec_tick && (gap_q == CNT_W'(DIV_NOM));

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q   <= '0;
         secs_q  <= '0;
         longs_q <= '0;
      end else if (sec_tick) begin
         gap_q <= '0;
         if (frame_tick) begin
            secs_q  <= '0;
            longs_q <= '0;
         end else begin
            secs_q  <= secs_q + 1'b1;
            longs_q <= longs_q + {{CORR_W{1'b0}}, cur_long};
         end
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!sec_tick && !frame_tick)); // R1

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
      !sec_tick |-> (gap_q < CNT_W'(DIV_NOM))); // R2

   AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
      sec_tick |-> ((gap_q == CNT_W'(DIV_NOM - 1)) || (gap_q == CNT_W'(DIV_NOM)))); // R2

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
      sec_tick |=> !sec_tick); // R3

   AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (rst)
      frame_tick |-> (sec_tick && (secs_q == POS_W'(FRAME_LEN - 1)))); // R4

   AST_LONG_TALLY: assert property (@(posedge clk) disable iff (rst)
      frame_tick |-> ((longs_q + {{CORR_W{1'b0}}, cur_long}) == {1'b0, act_corr})); // R5

   AST_CORR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !frame_tick |=> $stable(act_corr)); // R7

   AST_CORR_BOUND: assert property (@(posedge clk) disable iff (rst)
      act_corr <= CORR_W'(FRAME_LEN)); // R8

endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk #(
   .DIV_NOM   (DIV_NOM),
   .FRAME_LEN (FRAME_LEN),
   .CORR_W    (CORR_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .sec_tick   (sec_tick),
   .frame_tick (frame_tick),
   .act_corr   (act_corr)
);

// File: tb/rtc_trim_prescaler_bench.sv
module rtc_trim_prescaler_bench;

   localparam int DIV  = 12;
   localparam int FLEN = 6;
   localparam int CW   = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [CW-1:0] corr_n = '0;
   logic          sec_tick;
   logic          frame_tick;

   int    n_checks = 0;
   int    n_fail   = 0;
   int    exp_q[$];
   bit    end_q[$];
   int    fn_q[$];
   string tag_q[$];
   int    plan_q[$];

   always #5 clk = ~clk;

   rtc_trim_prescaler #(
      .DIV_NOM   (DIV),
      .FRAME_LEN (FLEN),
      .CORR_W    (CW)
   ) u_rtc_trim_prescaler (
      .clk        (clk),
      .rst        (rst),
      .corr_n     (corr_n),
      .sec_tick   (sec_tick),
      .frame_tick (frame_tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: expected second lengths for one frame with active correction n
   task automatic push_frame(input int n, input string tag);
      for (int k = 0; k < FLEN; k++) begin
         int extra;
         extra = ((k + 1) * n) / FLEN - (k * n) / FLEN;
         exp_q.push_back(DIV + extra);
         end_q.push_back(k == FLEN - 1);
      end
      fn_q.push_back(n);
      tag_q.push_back(tag);
   endtask

   // Monitor / scoreboard
   initial begin
      int  k;
      int  last;
      int  local_sec;
      int  fsum;
      int  flong;
      bit  first;
      bit  prev_tick;
      k = 0; last = -1; local_sec = 0; fsum = 0; flong = 0; first = 1'b1; prev_tick = 1'b0;
      forever begin
         @(negedge clk);
         if (rst) begin
            k = 0; last = -1; local_sec = 0; fsum = 0; flong = 0;
            first = 1'b1; prev_tick = 1'b0;
         end else begin
            k++;
            if (sec_tick) begin
               int gap;
               gap = k - last;
               last = k;
               check(!prev_tick, "R3", 1, 0);
               if (first) begin
                  check(k == DIV - 1, "R1", k, DIV - 1);
                  first = 1'b0;
               end
               if (exp_q.size() == 0) begin
                  check(1'b0, "R4", gap, 0);
               end else begin
                  int    e;
                  bit    fe;
                  string tg;
                  e  = exp_q.pop_front();
                  fe = end_q.pop_front();
                  tg = tag_q[0];
                  check(gap == e, tg, gap, e);
                  check(frame_tick == fe, "R4", int'(frame_tick), int'(fe));
                  fsum  += gap;
                  flong += gap - DIV;
                  local_sec++;
                  if (local_sec == 2 && plan_q.size() != 0) begin
                     corr_n = CW'(plan_q.pop_front());
                  end
                  if (fe) begin
                     int fn;
                     fn = fn_q.pop_front();
                     void'(tag_q.pop_front());
                     check(flong == fn, "R5", flong, fn);
                     check(fsum == FLEN * DIV + fn, "R10", fsum, FLEN * DIV + fn);
                     local_sec = 0; fsum = 0; flong = 0;
                  end
               end
            end else if (frame_tick) begin
               check(1'b0, "R4", 1, 0);
            end
            prev_tick = sec_tick;
         end
      end
   end

   task automatic drain(output bit hung);
      int waited;
      waited = 0;
      hung = 1'b0;
      while (exp_q.size() != 0) begin
         @(negedge clk);
         waited++;
         if (waited > 20000) begin
            hung = 1'b1;
            check(1'b0, "watchdog", waited, 0);
            return;
         end
      end
   endtask

   initial begin
      bit hung;
      // Phase 1: reset state, then a scripted series of corrections
      corr_n = CW'(4);
      repeat (4) @(negedge clk);
      check(!sec_tick && !frame_tick, "R1", int'(sec_tick), 0);
      push_frame(0, "R2");   // R1: first frame ignores corr_n held during reset
      push_frame(2, "R7");   // R7: value 2 written mid frame 0, used in frame 1
      push_frame(5, "R6");
      push_frame(6, "R9");   // R9: full correction, every second long
      push_frame(6, "R8");   // R8: request of 7 saturates to 6
      push_frame(3, "R6");   // R6: spreading pattern
      push_frame(1, "R6");
      push_frame(4, "R6");
      plan_q = '{2, 5, 6, 7, 3, 1, 4, 0};
      #1 rst = 1'b0;
      drain(hung);

      // Phase 2: reset partway through a second with a nonzero request held
      if (!hung) begin
         repeat (5) @(negedge clk);
         plan_q.delete();
         corr_n = CW'(5);
         #1 rst = 1'b1;
         repeat (3) @(negedge clk);
         check(!sec_tick && !frame_tick, "R1", int'(frame_tick), 0);
         push_frame(0, "R1");
         push_frame(5, "R7");
         @(negedge clk);
         #1 rst = 1'b0;
         drain(hung);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule